// File: doc/BRIEF.md
# Buck Converter Soft-Start and Fault Sequencer

This block is the digital supervisor that sits beside the analog loop of a voltage-mode synchronous buck controller. It holds the converter off until the supply-good flag rises. It then raises a digital reference code from zero to its nominal value in even steps, so that the output voltage comes up slowly and the inrush current stays limited. Once the ramp is complete, it hands regulation to the loop.

During operation it reacts to three comparator flags. An over-voltage flag pulls the low-side switch on for as long as the flag stays high. An under-voltage flag, which is ignored while the ramp is running, switches the converter off for a fixed restart delay and then starts the ramp again. This hiccup repeats as often as needed and never latches. An over-current flag switches the converter off for one cycle, restarts the ramp and advances a retry counter. On the fourth event the block latches with both gates off.

The latched state can be left in two ways: a shutdown request or a loss of supply-good. Either one also clears the retry counter. Releasing a shutdown request starts a fresh ramp.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, and whenever supply_ok is low, gates_off is 1 and pwm_en, force_low, fault_latched and ref_code are all 0. No start-up begins until supply_ok is 1.
- R2: The soft-start begins on the first clock edge at which supply_ok is high, shdn_req is low and the block is idle or shut down. From that edge, pwm_en is 1 and ref_code starts at 0. After n further cycles, ref_code equals min(n / STEP_CYC, REF_CODE), using integer division. It then holds at REF_CODE.
- R3: While ref_code is below REF_CODE during soft-start, uv_flag has no effect: gates_off stays 0 and the ramp continues.
- R4: When uv_flag is high after soft-start is complete, gates_off is 1 for exactly HICCUP_CYC cycles, counted from the first cycle of the shutdown. A new soft-start from ref_code 0 then follows. This repeats without ever latching.
- R5: An over-current event sets gates_off to 1 for exactly one cycle and advances the retry counter. A new soft-start from ref_code 0 follows. An over-current event is oc_flag high on an edge while the converter is ramping or regulating.
- R6: The OC_LIMIT-th over-current event (4 by default) sets fault_latched and gates_off to 1. Both stay at 1, whatever oc_flag, uv_flag and ov_flag do, while supply_ok is 1 and shdn_req is 0.
- R7: When ov_flag is high during soft-start or regulation, force_low is 1 and pwm_en is 0 on the next cycle. One cycle after ov_flag falls, force_low is 0, pwm_en is 1 and ref_code is unchanged.
- R8: While shdn_req is high, gates_off is 1 and fault_latched is 0. The request clears the retry counter. One cycle after it is released, a soft-start from ref_code 0 begins.
- R9: A low supply_ok returns the block to idle from any state, including the latched state, and clears the retry counter.
- R10: When flags coincide, shdn_req wins over a supply loss, which wins over over-current, which wins over over-voltage, which wins over under-voltage.
- R11: Exactly one of pwm_en, force_low and gates_off is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good flag; comparator hysteresis is applied upstream |
| shdn_req | input | 1 | External shutdown request, level sensitive |
| oc_flag | input | 1 | Over-current comparator output |
| uv_flag | input | 1 | Under-voltage comparator output (feedback below 67% of reference) |
| ov_flag | input | 1 | Over-voltage comparator output (feedback above 118% of reference) |
| ref_code | output | REF_W | Reference code for the error amplifier; ramps during soft-start |
| pwm_en | output | 1 | Enables the PWM loop |
| force_low | output | 1 | Requests the low-side switch on, with the high-side switch off |
| gates_off | output | 1 | Holds both switches off |
| fault_latched | output | 1 | Over-current latch-off status |

## Verification
The assertions assume that every input flag is already synchronous to clk and meets setup at each edge. A flag sampled high on one edge counts as one event, so an over-current flag held for several regulating cycles counts more than once. The properties on ramp masking and over-voltage response also take the comparator flags as independent of ref_code: nothing in the checker models the analog loop. The stimulus changes inputs only one nanosecond after a rising edge. It gives over-current as single-cycle pulses and releases under-voltage before the ramp completes, so that each event maps to exactly one state change.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SOFT   = 3'd1,
    SQ_RUN    = 3'd2,
    SQ_HICCUP = 3'd3,
    SQ_OCOFF  = 3'd4,
    SQ_LATCH  = 3'd5,
    SQ_SHDN   = 3'd6
  } seq_state_t;

  // The converter switches (ramping or regulating)
  function automatic logic is_regulating(input seq_state_t s);
    return (s == SQ_SOFT) || (s == SQ_RUN);
  endfunction

endpackage

// File: rtl/pwr_seq_ramp.sv
module pwr_seq_ramp #(
  parameter int REF_W    = 8,
  parameter int REF_CODE = 200,
  parameter int STEP_CYC = 1600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [REF_W-1:0] ramp_o,
  output logic             at_top_o
);
  localparam logic [REF_W-1:0] TOP = REF_W'(REF_CODE);
  localparam logic [REF_W-1:0] ONE = REF_W'(1);

  logic [REF_W-1:0] ramp_q;
  logic             step;

  generate
    if (STEP_CYC > 1) begin : g_div
      localparam int DW = $clog2(STEP_CYC);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst || clr)     div_q <= '0;
        else if (adv) begin
          if (div_q == DW'(STEP_CYC - 1)) div_q <= '0;
          else                            div_q <= div_q + 1'b1;
        end
      end
      assign step = adv && (div_q == DW'(STEP_CYC - 1));
    end else begin : g_nodiv
      assign step = adv;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)                 ramp_q <= '0;
    else if (step && ramp_q != TOP) ramp_q <= ramp_q + ONE;
  end

  assign ramp_o   = ramp_q;
  assign at_top_o = (ramp_q == TOP);
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CYC = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done_o
);
  localparam int TW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run && (cnt_q == TW'(CYC - 1));
endmodule

// File: rtl/pwr_seq_occnt.sv
module pwr_seq_occnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  // The next event is the one that reaches the limit
  assign last_o = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int REF_W      = 8,
  parameter int REF_CODE   = 200,
  parameter int STEP_CYC   = 1600,
  parameter int HICCUP_CYC = 65536,
  parameter int OC_LIMIT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok,
  input  logic             shdn_req,
  input  logic             oc_flag,
  input  logic             uv_flag,
  input  logic             ov_flag,
  output logic [REF_W-1:0] ref_code,
  output logic             pwm_en,
  output logic             force_low,
  output logic             gates_off,
  output logic             fault_latched
);
  seq_state_t st_q, st_d;
  logic       in_loop, ramp_top, hic_done, oc_last;

  assign in_loop = is_regulating(st_q);

  pwr_seq_ramp #(.REF_W(REF_W), .REF_CODE(REF_CODE), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst(rst), .clr(!in_loop), .adv(st_q == SQ_SOFT),
    .ramp_o(ref_code), .at_top_o(ramp_top)
  );

  pwr_seq_timer #(.CYC(HICCUP_CYC)) u_hiccup (
    .clk(clk), .rst(rst), .run(st_q == SQ_HICCUP), .done_o(hic_done)
  );

  pwr_seq_occnt #(.LIMIT(OC_LIMIT)) u_occnt (
    .clk(clk), .rst(rst), .clr(shdn_req || !supply_ok),
    .inc(oc_flag && in_loop), .last_o(oc_last)
  );

  // Priority: shutdown, supply loss, over-current, over-voltage, under-voltage
  always_comb begin
    st_d = st_q;
    if (shdn_req)        st_d = SQ_SHDN;
    else if (!supply_ok) st_d = SQ_IDLE;
    else begin
      unique case (st_q)
        SQ_IDLE, SQ_SHDN, SQ_OCOFF: st_d = SQ_SOFT;
        SQ_LATCH:  st_d = SQ_LATCH;
        SQ_HICCUP: st_d = hic_done ? SQ_SOFT : SQ_HICCUP;
        SQ_SOFT: begin
          if (oc_flag)       st_d = oc_last ? SQ_LATCH : SQ_OCOFF;
          else if (ramp_top) st_d = SQ_RUN;
        end
        SQ_RUN: begin
          if (oc_flag)                  st_d = oc_last ? SQ_LATCH : SQ_OCOFF;
          else if (uv_flag && !ov_flag) st_d = SQ_HICCUP;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= SQ_IDLE;
      pwm_en        <= 1'b0;
      force_low     <= 1'b0;
      gates_off     <= 1'b1;
      fault_latched <= 1'b0;
    end else begin
      st_q          <= st_d;
      pwm_en        <= is_regulating(st_d) && !ov_flag;
      force_low     <= is_regulating(st_d) && ov_flag;
      gates_off     <= !is_regulating(st_d);
      fault_latched <= (st_d == SQ_LATCH);
    end
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int REF_W    = 8,
  parameter int REF_CODE = 200
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok,
  input logic             shdn_req,
  input logic             oc_flag,
  input logic             uv_flag,
  input logic             ov_flag,
  input logic [REF_W-1:0] ref_code,
  input logic             pwm_en,
  input logic             force_low,
  input logic             gates_off,
  input logic             fault_latched
);
  a_r11_one_drive_mode: assert property (@(posedge clk) disable iff (rst)
    $countones({pwm_en, force_low, gates_off}) == 1);

  a_r2_ramp_bound: assert property (@(posedge clk) disable iff (rst)
    ref_code <= REF_W'(REF_CODE));

  a_r2_ramp_unit_step: assert property (@(posedge clk) disable iff (rst)
    (ref_code != $past(ref_code)) |->
      (ref_code == REF_W'($past(ref_code) + 1'b1)) || (ref_code == '0));

  a_r3_uv_masked: assert property (@(posedge clk) disable iff (rst)
    ((pwm_en || force_low) && ref_code < REF_W'(REF_CODE) && uv_flag &&
     !oc_flag && !shdn_req && supply_ok) |=> !gates_off);

  a_r6_latch_gates: assert property (@(posedge clk) disable iff (rst)
    fault_latched |-> gates_off);

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (rst)
    (fault_latched && supply_ok && !shdn_req) |=> fault_latched);

  a_r7_ov_force: assert property (@(posedge clk) disable iff (rst)
    ((pwm_en || force_low) && ov_flag && !oc_flag && !shdn_req && supply_ok)
      |=> force_low);

  a_r8_shutdown: assert property (@(posedge clk) disable iff (rst)
    shdn_req |=> gates_off && !fault_latched);

  a_r9_supply_loss: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> gates_off && !fault_latched);
endmodule

bind pwr_seq_top pwr_seq_chk #(.REF_W(REF_W), .REF_CODE(REF_CODE)) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .shdn_req(shdn_req),
  .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
  .ref_code(ref_code), .pwm_en(pwm_en), .force_low(force_low),
  .gates_off(gates_off), .fault_latched(fault_latched)
);

// File: tb/pwr_seq_top_bench.sv
`timescale 1ns/1ps
module pwr_seq_top_bench;
  localparam int RW = 4, RC = 10, SC = 3, HC = 20, OL = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic supply_ok = 1'b0, shdn_req = 1'b0;
  logic oc_flag = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
  logic [RW-1:0] ref_code;
  logic pwm_en, force_low, gates_off, fault_latched;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(.REF_W(RW), .REF_CODE(RC), .STEP_CYC(SC), .HICCUP_CYC(HC),
                .OC_LIMIT(OL)) u_pwr_seq_top (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .shdn_req(shdn_req),
    .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .ref_code(ref_code), .pwm_en(pwm_en), .force_low(force_low),
    .gates_off(gates_off), .fault_latched(fault_latched)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic oc_pulse();
    oc_flag = 1'b1; tick(); oc_flag = 1'b0;
  endtask

  // Called just after the edge that started a ramp
  task automatic wait_run();
    repeat (RC*SC + 2) tick();
    chk("R2 ramp complete", ref_code, RC);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    repeat (5) tick();
    chk("R1 gates_off idle", gates_off, 1);
    chk("R1 pwm_en idle", pwm_en, 0);
    chk("R1 ref_code idle", ref_code, 0);
    chk("R1 fault idle", fault_latched, 0);

    // Start-up ramp, with uv_flag high during the ramp (R2, R3)
    supply_ok = 1'b1; tick();
    chk("R2 pwm_en start", pwm_en, 1);
    chk("R2 ref_code start", ref_code, 0);
    for (int n = 1; n <= RC*SC + 3; n++) begin
      uv_flag = (n <= RC*SC - 1);
      tick();
      chk("R2 ramp value", ref_code, (n / SC > RC) ? RC : n / SC);
      chk("R3 uv masked in ramp", gates_off, 0);
    end
    uv_flag = 1'b0;

    // Hiccup, twice (R4)
    for (int rep = 0; rep < 2; rep++) begin
      int cnt;
      uv_flag = 1'b1; tick(); uv_flag = 1'b0;
      chk("R4 hiccup off", gates_off, 1);
      chk("R4 no latch", fault_latched, 0);
      cnt = 1;
      while (gates_off && cnt < 5*HC) begin
        tick();
        if (gates_off) cnt++;
      end
      chk("R4 hiccup length", cnt, HC);
      chk("R4 restart pwm_en", pwm_en, 1);
      chk("R4 restart ref_code", ref_code, 0);
      wait_run();
    end

    // Over-voltage with under-voltage at the same time (R7, R10)
    ov_flag = 1'b1; uv_flag = 1'b1; tick();
    chk("R7 force_low", force_low, 1);
    chk("R7 pwm_en off", pwm_en, 0);
    chk("R10 ov over uv", gates_off, 0);
    chk("R11 one mode", int'(pwm_en) + int'(force_low) + int'(gates_off), 1);
    repeat (3) tick();
    chk("R7 force_low held", force_low, 1);
    ov_flag = 1'b0; uv_flag = 1'b0; tick();
    chk("R7 release force_low", force_low, 0);
    chk("R7 resume pwm_en", pwm_en, 1);
    chk("R7 ref_code kept", ref_code, RC);

    // Over-current retries and latch (R5, R6)
    for (int k = 1; k < OL; k++) begin
      oc_pulse();
      chk("R5 oc off", gates_off, 1);
      chk("R5 oc no latch", fault_latched, 0);
      tick();
      chk("R5 oc single cycle", gates_off, 0);
      chk("R5 oc ramp restart", ref_code, 0);
      if (k == 1) wait_run(); else repeat (2) tick();
    end
    oc_pulse();
    chk("R6 latch set", fault_latched, 1);
    chk("R6 latch gates", gates_off, 1);
    for (int n = 0; n < 10; n++) begin
      oc_flag = n[0]; uv_flag = n[1]; ov_flag = n[2];
      tick();
      chk("R6 latch held", fault_latched, 1);
      chk("R6 no force_low", force_low, 0);
      chk("R6 no pwm_en", pwm_en, 0);
    end
    oc_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;

    // Shutdown clears latch and counter (R8)
    shdn_req = 1'b1; tick();
    chk("R8 shutdown clears latch", fault_latched, 0);
    chk("R8 shutdown gates", gates_off, 1);
    for (int n = 0; n < 3; n++) begin
      oc_flag = n[0]; tick();
      chk("R8 held off", gates_off, 1);
    end
    oc_flag = 1'b0; shdn_req = 1'b0; tick();
    chk("R8 release restart", pwm_en, 1);
    chk("R8 release ref_code", ref_code, 0);
    for (int k = 1; k < OL; k++) begin oc_pulse(); tick(); end
    shdn_req = 1'b1; tick(); shdn_req = 1'b0; tick();
    for (int k = 1; k < OL; k++) begin
      oc_pulse();
      chk("R8 counter cleared", fault_latched, 0);
      tick();
    end
    oc_pulse();
    chk("R6 latch after fresh count", fault_latched, 1);

    // Supply loss leaves the latch and clears the counter (R9, R1)
    supply_ok = 1'b0; tick();
    chk("R9 supply loss clears latch", fault_latched, 0);
    chk("R9 supply loss gates", gates_off, 1);
    repeat (3) tick();
    chk("R1 no start without supply", gates_off, 1);
    supply_ok = 1'b1; tick();
    chk("R9 restart", pwm_en, 1);
    for (int k = 1; k < OL; k++) begin
      oc_pulse();
      chk("R9 counter cleared", fault_latched, 0);
      tick();
    end

    // Priority (R10): count is OL-1 here
    shdn_req = 1'b1; oc_flag = 1'b1; tick();
    chk("R10 shutdown over oc", fault_latched, 0);
    oc_flag = 1'b0; shdn_req = 1'b0; tick();
    shdn_req = 1'b1; supply_ok = 1'b0; tick();
    chk("R10 shutdown with supply loss", gates_off, 1);
    shdn_req = 1'b0; tick();
    chk("R10 idle while supply low", gates_off, 1);
    supply_ok = 1'b1; tick();
    chk("R10 restart", pwm_en, 1);
    wait_run();
    oc_flag = 1'b1; ov_flag = 1'b1; tick();
    oc_flag = 1'b0; ov_flag = 1'b0;
    chk("R10 oc over ov gates", gates_off, 1);
    chk("R10 oc over ov force_low", force_low, 0);
    tick();
    chk("R10 oc restart", ref_code, 0);
    wait_run();
    oc_flag = 1'b1; uv_flag = 1'b1; tick();
    oc_flag = 1'b0; uv_flag = 1'b0;
    chk("R10 oc over uv gates", gates_off, 1);
    tick();
    chk("R10 oc over uv short off", gates_off, 0);
    chk("R11 one mode end", int'(pwm_en) + int'(force_low) + int'(gates_off), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule